// File: doc/BRIEF.md
# Local Bus Interrupt Priority Controller

This block gathers a set of level-sensitive interrupt request lines from local peripherals, gates them with an enable mask held in a register, and drives one combined interrupt line toward the processor. Each request line is sampled into a status flop every clock. The status therefore tracks the line: it is set while the line is high and clear once the line drops. No acknowledge, edge capture or nesting logic is involved.

Software reads a vector register. It returns a small encoded number that identifies the pending request with the lowest index, and that request has the highest priority. The encoding is `(index + 1) << 2`, so the value can serve directly as a word offset into a handler table, and zero means no request is pending. A second register holds the enable mask. It can be read and written, and it resets to a value with only bit 4 set. All register accesses are 16 bits wide and are decoded on byte offsets.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each status bit equals its request line as sampled at the previous rising clock edge, so raising or dropping a line changes `irq_o` and the vector read one clock later.
- R2: A request is pending when its status bit and its mask bit are both 1. `irq_o` is 1 exactly when at least one request is pending.
- R3: A read at byte offset 0x000 returns `(k + 1) << 2` in bits [15:0], where k is the index of the lowest pending request.
- R4: A read at offset 0x000 returns 0 when no request is pending, including when every line is high but the mask is 0.
- R5: Byte offset 0x002 holds the 16-bit enable mask, where bit i enables request line i. A write stores all 16 bits and a read returns them.
- R6: A mask write is applied at the clock edge that accepts it, so `irq_o` reflects the new mask one clock after the write is presented.
- R7: After reset the mask reads 0x0010, the status is all zero, `irq_o` is 0 and the vector reads 0.
- R8: A read at any offset other than 0x000 and 0x002 returns 0. A write to any offset other than 0x002, 0x000 included, leaves the mask unchanged.
- R9: When several requests are pending, the lowest index takes priority and sets the vector, whatever the higher pending bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 16 | Level-sensitive request lines, bit i is line i |
| reg_addr_i | input | 12 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that `irq_lvl_i` and the register inputs are stable around each rising edge. They also assume that a write strobe lasts a single cycle with its offset and data already valid. The bench drives every input on the falling edge, holds a write for exactly one cycle, and reads only after the inputs have settled half a period away from the sampling edge. Under these conditions the one-cycle latency of the request lines and of the mask holds. The vector read is then a pure function of the sampled state, so walking-one, priority-ladder and pseudo-random patterns can all be compared against arithmetic computed in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned IRQ_N    = 16;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned OFS_W    = 12;
  localparam logic [OFS_W-1:0] OFS_VEC  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_MASK = 12'h002;
  localparam logic [REG_W-1:0] MASK_RST = 16'h0010;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] stat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_o[g] <= 1'b0;
      else         stat_o[g] <= lvl_i[g];
    end
  end

  // one-cycle tracking check needs a cycle of history after reset
  logic hist_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= 1'b1;
  end

  assert_status_tracks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_q |-> (stat_o == $past(lvl_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= RST;
    else if (we_i) mask_o <= wdata_i;
  end

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_o == $past(wdata_i)));
  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] vec_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             any;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     num;

  // scan downward so the lowest set bit is the last one kept
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    num   = W'(idx) + W'(1);
    vec_o = any ? (num << 2) : '0;
  end

  logic [W-1:0]     chk_pos;
  logic [IDX_W-1:0] chk_idx;
  assign chk_pos = (vec_o >> 2) - W'(1);
  assign chk_idx = chk_pos[IDX_W-1:0];

  assert_vec_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == '0) == (pend_i == '0));
  assert_vec_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != '0) |-> (pend_i[chk_idx] &&
                       ((pend_i & ((N'(1) << chk_idx) - N'(1))) == '0)));
  assert_vec_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[1:0] == 2'b00);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ = IRQ_N,
  parameter int unsigned DATA_W  = REG_W,
  parameter int unsigned ADDR_W  = OFS_W,
  parameter logic [DATA_W-1:0] MASK_INIT = MASK_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_lvl_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic [NUM_IRQ-1:0] stat_q;
  logic [DATA_W-1:0]  mask_q;
  logic [NUM_IRQ-1:0] pend;
  logic [DATA_W-1:0]  vec;
  logic               mask_we;

  assign mask_we = reg_we_i && (reg_addr_i == A_MASK);

  irq_status_reg #(.N(NUM_IRQ)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_lvl_i),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.W(DATA_W), .RST(MASK_INIT)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  assign pend  = stat_q & mask_q[NUM_IRQ-1:0];
  assign irq_o = |pend;

  irq_prio_enc #(.N(NUM_IRQ), .W(DATA_W)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .vec_o  (vec)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_VEC:   reg_rdata_o = vec;
      A_MASK:  reg_rdata_o = mask_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assert_irq_vs_vec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec != '0));
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_i != A_VEC) && (reg_addr_i != A_MASK)) |-> (reg_rdata_o == '0));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lvl = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int vecs = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_lvl_i(irq_lvl), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    for (int i = 0; i < 16; i++)
      if (p[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic drive(input logic [15:0] v);
    @(negedge clk);
    irq_lvl = v;
    @(negedge clk);
  endtask

  task automatic check_state(input string req, input logic [15:0] lines, input logic [15:0] m);
    logic [15:0] d;
    rd(12'h000, d);
    chk(req, d, exp_vec(lines & m));
    chk(req, {15'b0, irq}, {15'b0, |(lines & m)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] seed;
    logic [15:0] m;
    logic [15:0] lines;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    chk("R7 irq", {15'b0, irq}, 16'h0);
    rd(12'h000, d); chk("R7 vec", d, 16'h0);
    rd(12'h002, d); chk("R7 mask", d, 16'h0010);
    drive(16'h0010);
    check_state("R7 reset mask enables line 4", 16'h0010, 16'h0010);
    drive(16'hFFEF);
    check_state("R7 reset mask blocks others", 16'hFFEF, 16'h0010);

    // R5 mask read/write
    wr(12'h002, 16'hA5C3);
    rd(12'h002, d); chk("R5 mask rw", d, 16'hA5C3);
    wr(12'h002, 16'hFFFF);
    rd(12'h002, d); chk("R5 mask all", d, 16'hFFFF);

    // R3 walking one
    for (int i = 0; i < 16; i++) begin
      drive(16'(1 << i));
      check_state("R3 walking one", 16'(1 << i), 16'hFFFF);
    end

    // R9 priority ladder: bits i..15 set
    for (int i = 0; i < 16; i++) begin
      lines = 16'hFFFF << i;
      drive(lines);
      check_state("R9 ladder", lines, 16'hFFFF);
    end

    // R4 nothing pending
    drive(16'h0000);
    check_state("R4 no lines", 16'h0000, 16'hFFFF);
    wr(12'h002, 16'h0000);
    drive(16'hFFFF);
    check_state("R4 mask zero", 16'hFFFF, 16'h0000);

    // R1 line drop clears one clock later
    wr(12'h002, 16'h0040);
    drive(16'h0040);
    check_state("R1 raised", 16'h0040, 16'h0040);
    @(negedge clk);
    irq_lvl = 16'h0000;
    #1;
    chk("R1 before edge", {15'b0, irq}, 16'h1);
    @(negedge clk);
    check_state("R1 dropped", 16'h0000, 16'h0040);

    // R6 mask write reaches irq_o one clock later
    wr(12'h002, 16'h0000);
    drive(16'h0100);
    chk("R6 masked", {15'b0, irq}, 16'h0);
    @(negedge clk);
    addr = 12'h002; wdata = 16'h0100; we = 1'b1;
    #1;
    chk("R6 before edge", {15'b0, irq}, 16'h0);
    @(negedge clk);
    we = 1'b0;
    chk("R6 after edge", {15'b0, irq}, 16'h1);

    // R8 unmapped reads and ignored writes
    wr(12'h000, 16'h1234);
    wr(12'h004, 16'hFFFF);
    wr(12'h003, 16'hFFFF);
    wr(12'hFFE, 16'hFFFF);
    rd(12'h002, d); chk("R8 mask kept", d, 16'h0100);
    check_state("R8 output kept", 16'h0100, 16'h0100);
    rd(12'h001, d); chk("R8 rd 0x001", d, 16'h0);
    rd(12'h004, d); chk("R8 rd 0x004", d, 16'h0);
    rd(12'hFFF, d); chk("R8 rd 0xFFF", d, 16'h0);

    // R2 pseudo-random lines and masks
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      m = seed[31:16];
      seed = seed * 32'd1664525 + 32'd1013904223;
      lines = seed[31:16] & seed[23:8];
      wr(12'h002, m);
      drive(lines);
      check_state("R2 random", lines, m);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule